// File: doc/BRIEF.md
# Saturating Doubling High Multiplier

This block is a lane-parallel signed fractional multiplier for packed 16-bit data. Every lane takes two two's-complement operands, forms their full 32-bit product and returns that product divided by 2^15. The division rounds toward negative infinity. The result is the same as doubling the product and keeping its upper half, which is the usual Q15 × Q15 → Q15 multiply.

Only one operand pair cannot be represented: minus full scale times minus full scale would give +32768. That lane is clamped to +32767 instead, and a sticky flag records that saturation happened at least once.

The block has two register stages and a fixed latency of two cycles. A new vector may enter on every cycle. Results load only when a valid item reaches the output stage, and they hold otherwise. The sticky flag stays set until the user pulses a clear input.

Top module: `sdh_mul_top`

## Requirements
- R1: For each lane whose operands are not both -32768 (0x8000), the result is floor(a*b / 32768), taken as a 16-bit two's-complement value. No rounding constant is added, so for example 0xFFFF × 0x0001 gives 0xFFFF.
- R2: A lane whose two operands are both 0x8000 gives 0x7FFF.
- R3: Lanes are independent. Lane k occupies bits [16k+15:16k] of each operand bus and of the result, with lane 0 in the least significant bits.
- R4: `out_vld` equals `in_vld` from exactly two rising edges earlier, so back-to-back vectors emerge back to back.
- R5: `out_res` changes only in cycles where `out_vld` is high. It keeps its previous value otherwise.
- R6: `sat_flag` rises in the same cycle that `out_vld` presents a vector containing a clamped lane. It then stays high until a clear.
- R7: When `sat_clr` is high at a rising edge, `sat_flag` is low after that edge. The exception is when a clamped vector reaches the output at that same edge: setting wins over clearing.
- R8: During and right after synchronous reset, `out_vld`, `out_res` and `sat_flag` are all zero.
- R9: Operands presented while `in_vld` is low have no effect on `out_res`, on `out_vld` or on `sat_flag`, even when they are the clamping pair.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| in_vld | input | 1 | Operand vectors are valid this cycle |
| in_a | input | N_LANES*16 | Packed first operands, lane 0 in the LSBs |
| in_b | input | N_LANES*16 | Packed second operands, lane 0 in the LSBs |
| sat_clr | input | 1 | Clears the sticky saturation flag |
| out_vld | output | 1 | Result vector is valid this cycle |
| out_res | output | N_LANES*16 | Packed lane results |
| sat_flag | output | 1 | Sticky: some lane has clamped since the last clear |

## Verification
The hardest case to reach is a clear that lands on the same edge as a clamped vector entering the output stage. It can only be created by timing `sat_clr` one cycle after the clamping pair is offered. The bench issues the pair, drops `in_vld`, and raises `sat_clr` on the following cycle so that both events meet at one edge. Near-corner pairs are also walked through every lane in rotation: 0x8000 with 0x7FFF, 0x8000 with 0xFFFF, and 0x7FFF with 0x8001. This shows that only the exact double minimum clamps, and that each lane position carries its own result.

// File: rtl/sdh_pkg.sv
package sdh_pkg;

    localparam int LANE_W  = 16;
    localparam int PROD_W  = 2 * LANE_W;
    localparam int FRAC_SH = LANE_W - 1;

    typedef logic signed [LANE_W-1:0] lane_t;
    typedef logic signed [PROD_W-1:0] prod_t;

    localparam lane_t LANE_MIN = {1'b1, {(LANE_W-1){1'b0}}};
    localparam lane_t LANE_MAX = {1'b0, {(LANE_W-1){1'b1}}};

    // first-stage contents of one lane
    typedef struct packed {
        prod_t prod;
        logic  corner;
    } stage1_t;

    function automatic logic is_corner(lane_t a, lane_t b);
        return (a == LANE_MIN) && (b == LANE_MIN);
    endfunction

    // floor(prod / 2^FRAC_SH); fits in LANE_W bits whenever the pair is not the corner
    function automatic lane_t high_part(prod_t p);
        return p[PROD_W-2 -: LANE_W];
    endfunction

endpackage

// File: rtl/sdh_valid_pipe.sv
module sdh_valid_pipe #(
    parameter int DEPTH = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             vld_in,
    output logic [DEPTH-1:0] vld_taps
);
    logic [DEPTH-1:0] sr_q;

    always_ff @(posedge clk) begin
        if (rst) sr_q <= '0;
        else     sr_q <= {sr_q[DEPTH-2:0], vld_in};
    end

    assign vld_taps = sr_q;
endmodule

// File: rtl/sdh_lane.sv
module sdh_lane
    import sdh_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  ld1,
    input  logic  ld2,
    input  lane_t op_a,
    input  lane_t op_b,
    output lane_t res,
    output logic  corner1
);
    stage1_t s1_q;
    prod_t   prod_c;
    lane_t   res_q;

    always_comb prod_c = PROD_W'(op_a) * PROD_W'(op_b);

    always_ff @(posedge clk) begin
        if (rst)      s1_q <= '0;
        else if (ld1) s1_q <= '{prod: prod_c, corner: is_corner(op_a, op_b)};
    end

    always_ff @(posedge clk) begin
        if (rst)      res_q <= '0;
        else if (ld2) res_q <= s1_q.corner ? LANE_MAX : high_part(s1_q.prod);
    end

    assign res     = res_q;
    assign corner1 = s1_q.corner;

    a_r2_corner_clamps: assert property (@(posedge clk) disable iff (rst)
        (ld2 && s1_q.corner) |=> (res_q == LANE_MAX));

    a_r1_neg_stays_neg: assert property (@(posedge clk) disable iff (rst)
        (ld2 && s1_q.prod < 0) |=> res_q[LANE_W-1]);

    a_r1_pos_stays_pos: assert property (@(posedge clk) disable iff (rst)
        (ld2 && !s1_q.corner && s1_q.prod >= 0) |=> !res_q[LANE_W-1]);

    a_r5_hold_when_idle: assert property (@(posedge clk) disable iff (rst)
        !ld2 |=> $stable(res_q));
endmodule

// File: rtl/sdh_sticky.sv
module sdh_sticky (
    input  logic clk,
    input  logic rst,
    input  logic hit,
    input  logic clr,
    output logic flag
);
    logic flag_q;

    always_ff @(posedge clk) begin
        if (rst)      flag_q <= 1'b0;
        else if (hit) flag_q <= 1'b1;
        else if (clr) flag_q <= 1'b0;
    end

    assign flag = flag_q;

    a_r6_stays_set: assert property (@(posedge clk) disable iff (rst)
        (flag_q && !clr) |=> flag_q);

    a_r7_set_beats_clear: assert property (@(posedge clk) disable iff (rst)
        hit |=> flag_q);

    a_r7_clear_works: assert property (@(posedge clk) disable iff (rst)
        (clr && !hit) |=> !flag_q);

    a_r9_no_spurious_set: assert property (@(posedge clk) disable iff (rst)
        (!hit && !flag_q) |=> !flag_q);
endmodule

// File: rtl/sdh_mul_top.sv
module sdh_mul_top
    import sdh_pkg::*;
#(
    parameter int N_LANES = 4,
    localparam int VEC_W  = N_LANES * LANE_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_vld,
    input  logic [VEC_W-1:0] in_a,
    input  logic [VEC_W-1:0] in_b,
    input  logic             sat_clr,
    output logic             out_vld,
    output logic [VEC_W-1:0] out_res,
    output logic             sat_flag
);
    localparam int STAGES = 2;

    logic [STAGES-1:0]  vtap;
    logic [N_LANES-1:0] corner1;
    logic               sat_hit;

    sdh_valid_pipe #(.DEPTH(STAGES)) u_vpipe (
        .clk      (clk),
        .rst      (rst),
        .vld_in   (in_vld),
        .vld_taps (vtap)
    );

    for (genvar k = 0; k < N_LANES; k++) begin : g_lane
        sdh_lane u_lane (
            .clk     (clk),
            .rst     (rst),
            .ld1     (in_vld),
            .ld2     (vtap[0]),
            .op_a    (in_a[k*LANE_W +: LANE_W]),
            .op_b    (in_b[k*LANE_W +: LANE_W]),
            .res     (out_res[k*LANE_W +: LANE_W]),
            .corner1 (corner1[k])
        );
    end

    assign sat_hit = vtap[0] && (|corner1);

    sdh_sticky u_sticky (
        .clk  (clk),
        .rst  (rst),
        .hit  (sat_hit),
        .clr  (sat_clr),
        .flag (sat_flag)
    );

    assign out_vld = vtap[STAGES-1];

    // cycles since reset, saturating, so the latency check never looks before reset
    logic [1:0] age_q;
    always_ff @(posedge clk) begin
        if (rst)              age_q <= '0;
        else if (age_q != 2'd2) age_q <= age_q + 2'd1;
    end

    a_r4_valid_latency: assert property (@(posedge clk) disable iff (rst)
        (age_q == 2'd2) |-> (out_vld == $past(in_vld, 2)));

    a_r6_flag_with_output: assert property (@(posedge clk) disable iff (rst)
        ($rose(sat_flag) && age_q == 2'd2) |-> out_vld);
endmodule

// File: tb/sim_sdh_mul_top.sv
`timescale 1ns/1ps
module sim_sdh_mul_top;
    localparam int NL   = 4;
    localparam int VW   = NL * 16;
    localparam int NROW = 14;

    // {a, b, expected}
    localparam logic [47:0] TV [NROW] = '{
        {16'h4000, 16'h4000, 16'h2000},
        {16'hFFFF, 16'hFFFF, 16'h0000},
        {16'hFFFF, 16'h0001, 16'hFFFF},
        {16'h7FFF, 16'h7FFF, 16'h7FFE},
        {16'h8000, 16'h7FFF, 16'h8001},
        {16'h8000, 16'h8000, 16'h7FFF},
        {16'h0000, 16'h1234, 16'h0000},
        {16'h8000, 16'h0001, 16'hFFFF},
        {16'h0003, 16'hFFFB, 16'hFFFF},
        {16'h4000, 16'hC000, 16'hE000},
        {16'h2000, 16'h0004, 16'h0001},
        {16'h7FFF, 16'h8001, 16'h8001},
        {16'h0001, 16'h0001, 16'h0000},
        {16'h8000, 16'hFFFF, 16'h0001}
    };

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          in_vld = 1'b0;
    logic [VW-1:0] in_a = '0;
    logic [VW-1:0] in_b = '0;
    logic          sat_clr = 1'b0;
    logic          out_vld;
    logic [VW-1:0] out_res;
    logic          sat_flag;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    sdh_mul_top #(.N_LANES(NL)) u0 (
        .clk(clk), .rst(rst), .in_vld(in_vld), .in_a(in_a), .in_b(in_b),
        .sat_clr(sat_clr), .out_vld(out_vld), .out_res(out_res), .sat_flag(sat_flag)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic int rix(int i, int k);
        return (i + k * 5) % NROW;
    endfunction

    task automatic load_row(input int i);
        for (int k = 0; k < NL; k++) begin
            in_a[k*16 +: 16] = TV[rix(i, k)][47:32];
            in_b[k*16 +: 16] = TV[rix(i, k)][31:16];
        end
    endtask

    function automatic logic [VW-1:0] exp_row(int i);
        logic [VW-1:0] e;
        for (int k = 0; k < NL; k++) e[k*16 +: 16] = TV[rix(i, k)][15:0];
        return e;
    endfunction

    initial begin
        #200000;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [VW-1:0] held;
        in_a = {NL{16'h8000}};
        in_b = {NL{16'h8000}};
        in_vld = 1'b1;
        repeat (3) @(negedge clk);
        // R8: reset state while valid clamping data is offered
        chk("R8 reset vld", 64'(out_vld), 64'd0);
        chk("R8 reset res", 64'(out_res), 64'd0);
        chk("R8 reset flag", 64'(sat_flag), 64'd0);
        rst = 1'b0;
        in_vld = 1'b0;
        @(negedge clk);
        @(negedge clk);
        chk("R8 after reset vld", 64'(out_vld), 64'd0);
        chk("R9 idle corner flag", 64'(sat_flag), 64'd0);

        // R9: clamping pair with in_vld low
        repeat (3) @(negedge clk);
        chk("R9 idle res", 64'(out_res), 64'd0);
        chk("R9 idle flag", 64'(sat_flag), 64'd0);

        // R1 R3 R4 R5: streamed table walk, one vector per cycle
        for (int c = 0; c < NROW + 2; c++) begin
            if (c >= 2) begin
                chk("R4 stream vld", 64'(out_vld), 64'd1);
                chk("R1 R3 stream res", 64'(out_res), 64'(exp_row(c - 2)));
            end
            if (c < NROW) begin
                load_row(c);
                in_vld = 1'b1;
            end else begin
                in_vld = 1'b0;
                in_a = {NL{16'h7FFF}};
                in_b = {NL{16'h7FFF}};
            end
            @(negedge clk);
        end
        // R5: bubble holds the last result
        held = out_res;
        chk("R4 bubble vld", 64'(out_vld), 64'd0);
        @(negedge clk);
        chk("R5 hold res", 64'(out_res), 64'(held));
        // R6: table contained the corner pair
        chk("R6 flag set", 64'(sat_flag), 64'd1);

        // R7: clear
        sat_clr = 1'b1;
        @(negedge clk);
        sat_clr = 1'b0;
        chk("R7 cleared", 64'(sat_flag), 64'd0);

        // R3 R2: only lane 2 clamps
        in_a = '0; in_b = '0;
        in_a[47:32] = 16'h8000; in_b[47:32] = 16'h8000;
        in_vld = 1'b1;
        @(negedge clk);
        in_vld = 1'b0;
        @(negedge clk);
        chk("R2 R3 lane2 only", 64'(out_res), 64'h0000_7FFF_0000_0000);
        chk("R6 flag with output", 64'(sat_flag), 64'd1);
        @(negedge clk);
        @(negedge clk);
        chk("R6 flag holds", 64'(sat_flag), 64'd1);
        sat_clr = 1'b1;
        @(negedge clk);
        sat_clr = 1'b0;
        chk("R7 cleared again", 64'(sat_flag), 64'd0);

        // R6: non-clamping vector leaves flag low
        in_a = {NL{16'h8000}};
        in_b = {NL{16'h7FFF}};
        in_vld = 1'b1;
        @(negedge clk);
        in_vld = 1'b0;
        @(negedge clk);
        chk("R1 near corner", 64'(out_res), {NL{16'h8001}});
        chk("R6 no clamp no flag", 64'(sat_flag), 64'd0);

        // R7: clear meets clamped vector at the same edge
        in_a = {NL{16'h8000}};
        in_b = {NL{16'h8000}};
        in_vld = 1'b1;
        @(negedge clk);
        in_vld = 1'b0;
        sat_clr = 1'b1;
        @(negedge clk);
        sat_clr = 1'b0;
        chk("R7 set wins", 64'(sat_flag), 64'd1);
        chk("R2 all lanes", 64'(out_res), {NL{16'h7FFF}});

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule